// File: doc/BRIEF.md
# Cartridge Memory Bank Controller

This block sits between an 8-bit CPU bus with 16-bit addresses and a banked ROM and RAM. CPU writes into the ROM address range are not stored in memory. The block decodes them as commands that set three registers: a 9-bit switchable ROM bank number, a 4-bit RAM bank number and a RAM enable flag.

The block uses these registers to turn each CPU address into an extended 23-bit ROM address and a 17-bit RAM address. It also drives the RAM chip select and write enable. The lower 16 KiB ROM window always shows bank 0. The upper 16 KiB window shows the selected bank, and bank 0 is a legal choice there. The register loads take one synchronous write strobe. The address and select outputs are combinational from the current CPU address and the registers.

Top module: `cartBankCtrl`

## Requirements
- R1: While reset is low, and after it is released, the switchable ROM bank is 0x001, the RAM bank is 0 and RAM is disabled.
- R2: A write with address in 0x2000–0x2FFF loads the 8 data bits into ROM bank bits 7..0 and leaves bit 8 as it was (0x42 gives 0x042 from reset).
- R3: A write with address in 0x3000–0x3FFF loads data bit 0 into ROM bank bit 8 and leaves bits 7..0 as they were (0x01 after 0x42 gives 0x142).
- R4: ROM bank 0x000 and 0x100 can both be selected in the switchable window. Bank 0 is never replaced by bank 1.
- R5: For CPU addresses 0x0000–0x3FFF, romAddr[22:14] is 0 whatever the registers hold.
- R6: A write with address in 0x0000–0x1FFF sets the RAM enable flag when the data is exactly 0x0A. Any other data byte, 0x1A among them, clears it.
- R7: A write with address in 0x4000–0x5FFF loads data bits 3..0 into the RAM bank (0x1F gives 0xF, 0x7A gives 0xA).
- R8: For CPU addresses 0x4000–0x7FFF, romAddr equals {romBank[8:0], cpuAddr[13:0]}. For 0x0000–0x3FFF, romAddr equals {9'h000, cpuAddr[13:0]}. romSel is high exactly when cpuAddr[15] is 0.
- R9: ramAddr always equals {ramBank[3:0], cpuAddr[12:0]}. ramCs is high only when cpuAddr is in 0xA000–0xBFFF and RAM is enabled. ramWe is ramCs qualified by cpuWr.
- R10: Writes with address in 0x6000–0x7FFF change no register.
- R11: Registers change only on a rising clock edge with cpuWr high and cpuAddr in 0x0000–0x7FFF. Writes to 0x8000–0xFFFF, and address or data changes while cpuWr is low, change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| cpuAddr | input | 16 | CPU address |
| cpuData | input | 8 | CPU write data |
| cpuWr | input | 1 | Write strobe, sampled on the rising edge |
| romSel | output | 1 | CPU address lies in the ROM range |
| romAddr | output | 23 | Extended ROM address |
| ramCs | output | 1 | RAM chip select |
| ramWe | output | 1 | RAM write enable |
| ramAddr | output | 17 | Extended RAM address |

## Verification
A register write takes effect at the rising edge on which cpuWr is sampled high. Every address and select output is combinational, so the register effect becomes visible as soon as a new address is applied after that edge. The bench therefore drives each write at a falling edge and lets one rising edge capture it. It then drops cpuWr at the next falling edge, applies a read address and samples one time unit later. It never samples at a clock edge. The reset state is checked both during reset and after release, before any write.

// File: rtl/cartBankPkg.sv
package cartBankPkg;
  localparam int ADDR_W     = 16;
  localparam int DATA_W     = 8;
  localparam int ROM_BANK_W = 9;
  localparam int RAM_BANK_W = 4;
  localparam int ROM_OFF_W  = 14;
  localparam int RAM_OFF_W  = 13;
  localparam int ROM_ADDR_W = ROM_BANK_W + ROM_OFF_W;
  localparam int RAM_ADDR_W = RAM_BANK_W + RAM_OFF_W;

  typedef struct packed {
    logic ramEnWr;   // write to the RAM enable command range
    logic romLoWr;   // write to the low byte of the ROM bank
    logic romHiWr;   // write to ROM bank bit 8
    logic ramBankWr; // write to the RAM bank
    logic romSwSel;  // address in the switchable ROM window
    logic ramSel;    // address in the external RAM window
  } bankStb_t;
endpackage

// File: rtl/cartBankCtrl_decode.sv
module cartBankCtrl_decode
  import cartBankPkg::*;
(
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuWr,
  output bankStb_t          stb
);
  logic [3:0] nib;
  logic       inRom;

  assign nib   = cpuAddr[ADDR_W-1 -: 4];
  assign inRom = ~cpuAddr[ADDR_W-1];

  always_comb begin
    stb           = '0;
    stb.romSwSel  = inRom & cpuAddr[ADDR_W-2];
    stb.ramSel    = (nib[3:1] == 3'b101);
    if (cpuWr && inRom) begin
      stb.ramEnWr   = (nib[3:1] == 3'b000);
      stb.romLoWr   = (nib == 4'h2);
      stb.romHiWr   = (nib == 4'h3);
      stb.ramBankWr = (nib[3:1] == 3'b010);
    end
  end
endmodule

// File: rtl/cartBankCtrl_datapath.sv
module cartBankCtrl_datapath
  import cartBankPkg::*;
#(
  parameter logic [DATA_W-1:0] ENABLE_KEY = 8'h0A
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  bankStb_t              stb,
  input  logic [ADDR_W-1:0]     cpuAddr,
  input  logic [DATA_W-1:0]     wrData,
  input  logic                  cpuWr,
  output logic [ROM_ADDR_W-1:0] romAddr,
  output logic [RAM_ADDR_W-1:0] ramAddr,
  output logic                  ramCs,
  output logic                  ramWe
);
  logic [ROM_BANK_W-1:0] romBank;
  logic [RAM_BANK_W-1:0] ramBank;
  logic                  ramEn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      romBank <= ROM_BANK_W'(1);
      ramBank <= '0;
      ramEn   <= 1'b0;
    end else begin
      if (stb.romLoWr)   romBank[7:0] <= wrData;
      if (stb.romHiWr)   romBank[8]   <= wrData[0];
      if (stb.ramBankWr) ramBank      <= wrData[RAM_BANK_W-1:0];
      if (stb.ramEnWr)   ramEn        <= (wrData == ENABLE_KEY);
    end
  end

  always_comb begin
    romAddr = {(stb.romSwSel ? romBank : ROM_BANK_W'(0)), cpuAddr[ROM_OFF_W-1:0]};
    ramAddr = {ramBank, cpuAddr[RAM_OFF_W-1:0]};
    ramCs   = stb.ramSel & ramEn;
    ramWe   = ramCs & cpuWr;
  end

  assert_one_strobe_R11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.ramEnWr, stb.romLoWr, stb.romHiWr, stb.ramBankWr}));

  assert_lo_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    stb.romLoWr |=> (romBank[7:0] == $past(wrData)) && $stable(romBank[8]));

  assert_hi_keep_R3: assert property (@(posedge clk) disable iff (!rstN)
    stb.romHiWr |=> (romBank[8] == $past(wrData[0])) && $stable(romBank[7:0]));

  assert_ram_bank_R7: assert property (@(posedge clk) disable iff (!rstN)
    stb.ramBankWr |=> ramBank == $past(wrData[RAM_BANK_W-1:0]));

  assert_idle_stable_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.ramEnWr | stb.romLoWr | stb.romHiWr | stb.ramBankWr)
      |=> $stable(romBank) && $stable(ramBank) && $stable(ramEn));
endmodule

// File: rtl/cartBankCtrl.sv
module cartBankCtrl
  import cartBankPkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     cpuAddr,
  input  logic [DATA_W-1:0]     cpuData,
  input  logic                  cpuWr,
  output logic                  romSel,
  output logic [ROM_ADDR_W-1:0] romAddr,
  output logic                  ramCs,
  output logic                  ramWe,
  output logic [RAM_ADDR_W-1:0] ramAddr
);
  bankStb_t stb;

  assign romSel = ~cpuAddr[ADDR_W-1];

  cartBankCtrl_decode u_decode (
    .cpuAddr(cpuAddr),
    .cpuWr  (cpuWr),
    .stb    (stb)
  );

  cartBankCtrl_datapath u_datapath (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .cpuAddr(cpuAddr),
    .wrData (cpuData),
    .cpuWr  (cpuWr),
    .romAddr(romAddr),
    .ramAddr(ramAddr),
    .ramCs  (ramCs),
    .ramWe  (ramWe)
  );

  assert_fixed_window_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cpuAddr[15:14] == 2'b00) |-> (romAddr[22:14] == 9'h000));

  assert_ram_gate_R9: assert property (@(posedge clk) disable iff (!rstN)
    ramCs |-> (cpuAddr[15:13] == 3'b101));

  assert_we_gate_R9: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |-> (ramCs && cpuWr));
endmodule

// File: tb/cartBankCtrl_bench.sv
module cartBankCtrl_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] cpuAddr = '0;
  logic [7:0]  cpuData = '0;
  logic        cpuWr = 1'b0;
  logic        romSel;
  logic [22:0] romAddr;
  logic        ramCs;
  logic        ramWe;
  logic [16:0] ramAddr;

  int nChecks = 0;
  int nFails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cartBankCtrl u_cartBankCtrl (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuData(cpuData), .cpuWr(cpuWr),
    .romSel(romSel), .romAddr(romAddr), .ramCs(ramCs), .ramWe(ramWe), .ramAddr(ramAddr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpuAddr = a; cpuData = d; cpuWr = 1'b1;
    @(negedge clk);
    cpuWr = 1'b0;
  endtask

  task automatic look(input logic [15:0] a);
    cpuAddr = a;
    #1;
  endtask

  // Switchable bank as seen at 0x4000, RAM bank and enable as seen at 0xA000
  function automatic logic [8:0] curRomBank();
    return romAddr[22:14];
  endfunction

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; cpuWr = 1'b0;
    @(negedge clk);
    look(16'h4000);
    check("R1 bank during reset", curRomBank(), 9'h001);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic testReset();
    doReset();
    look(16'h4000); check("R1 rom bank", curRomBank(), 9'h001);
    look(16'hA000); check("R1 ram cs off", ramCs, 1'b0);
    check("R1 ram bank", ramAddr[16:13], 4'h0);
  endtask

  task automatic testRomBanks();
    doReset();
    look(16'h4123); check("R8 switch addr", romAddr, {9'h001, 14'h0123});
    busWrite(16'h2000, 8'h42);
    look(16'h4000); check("R2 low byte", curRomBank(), 9'h042);
    busWrite(16'h3000, 8'h01);
    look(16'h7FFF); check("R3 high bit", romAddr, {9'h142, 14'h3FFF});
    busWrite(16'h2ABC, 8'h00);
    look(16'h4000); check("R4 bank 0x100", curRomBank(), 9'h100);
    busWrite(16'h3FFF, 8'hFE);
    look(16'h4000); check("R4 bank 0x000", curRomBank(), 9'h000);
    busWrite(16'h2000, 8'hFF);
    busWrite(16'h3000, 8'h01);
    look(16'h1234); check("R5 fixed window", romAddr, {9'h000, 14'h1234});
    check("R8 romSel low", romSel, 1'b1);
    look(16'h3FFF); check("R5 fixed top", romAddr[22:14], 9'h000);
    look(16'h8000); check("R8 romSel high addr", romSel, 1'b0);
  endtask

  task automatic testRamEnable();
    doReset();
    busWrite(16'h0000, 8'h0A);
    look(16'hA000); check("R6 enable 0x0A", ramCs, 1'b1);
    busWrite(16'h0000, 8'h1A);
    look(16'hA000); check("R6 clear 0x1A", ramCs, 1'b0);
    busWrite(16'h1FFF, 8'h0A);
    look(16'hBFFF); check("R6 enable top", ramCs, 1'b1);
    look(16'hC000); check("R9 cs outside window", ramCs, 1'b0);
    look(16'h9FFF); check("R9 cs below window", ramCs, 1'b0);
    @(negedge clk);
    cpuAddr = 16'hA010; cpuData = 8'h55; cpuWr = 1'b1; #1;
    check("R9 we when enabled", ramWe, 1'b1);
    @(negedge clk); cpuWr = 1'b0; #1;
    check("R9 we idle", ramWe, 1'b0);
    busWrite(16'h0800, 8'h00);
    @(negedge clk);
    cpuAddr = 16'hA010; cpuWr = 1'b1; #1;
    check("R9 we blocked", ramWe, 1'b0);
    @(negedge clk); cpuWr = 1'b0;
  endtask

  task automatic testRamBank();
    doReset();
    busWrite(16'h4000, 8'h1F);
    look(16'hA001); check("R7 0x1F", ramAddr, {4'hF, 13'h0001});
    busWrite(16'h5FFF, 8'h7A);
    look(16'hBFFF); check("R9 ram addr", ramAddr, {4'hA, 13'h1FFF});
  endtask

  task automatic testNoEffect();
    doReset();
    busWrite(16'h2000, 8'h33);
    busWrite(16'h4000, 8'h05);
    busWrite(16'h6000, 8'h77);
    busWrite(16'h7FFF, 8'h0A);
    look(16'h4000); check("R10 rom bank kept", curRomBank(), 9'h033);
    look(16'hA000); check("R10 ram bank kept", ramAddr[16:13], 4'h5);
    check("R10 ram stays off", ramCs, 1'b0);
    busWrite(16'hA000, 8'h0A);
    busWrite(16'h8000, 8'h99);
    busWrite(16'hE000, 8'h01);
    @(negedge clk);
    cpuAddr = 16'h2000; cpuData = 8'hEE; cpuWr = 1'b0;
    @(negedge clk);
    look(16'h4000); check("R11 rom bank kept", curRomBank(), 9'h033);
    look(16'hA000); check("R11 ram off", ramCs, 1'b0);
    check("R11 ram bank kept", ramAddr[16:13], 4'h5);
  endtask

  initial begin
    fork
      begin
        testReset();
        testRomBanks();
        testRamEnable();
        testRamBank();
        testNoEffect();
      end
      begin
        repeat (5000) @(posedge clk);
        nChecks++; nFails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule